// File: doc/BRIEF.md
# Multi-Cluster CPU Reset Controller

This block owns the reset lines of a multi-cluster processor complex. It has up to four clusters of up to four cores. Every core has three reset domains: the core itself, its SIMD unit and its debug logic. Every cluster adds two shared domains, the L2 cache and the cluster debug logic.

Software drives these domains through a plain 32-bit register bus. Each cluster has three registers:
- a set-style register that puts domains into reset;
- a clear-style register that takes domains out of reset;
- a status word that shows the settled reset state together with each core's WFI, WFE and debug-acknowledge indications.

An optional gating mode holds a core-reset request back until that core signals WFI. A core that is still draining its caches is therefore not cut off part way through.

The core status inputs come from other clock domains. Each passes through a two-flop synchroniser before it is used or reported. The status copy of the reset state trails the reset outputs by a fixed settling delay. Software that polls a status bit therefore sees a real lag, not an instant echo of its write.

Top module: `cpu_rst_ctrl`

## Requirements
- R1: After the block's reset, every domain is held in reset, except the boot domains of cluster 0: core 0, SIMD 0, core-0 debug, L2 and cluster debug. These boot domains are released.
- R2: A bus write to offset 0x520 + 8*c (the assert register) with bit b set puts domain b of cluster c into reset. The reset output is high after the clock edge that accepts the write. A write of bit b to 0x524 + 8*c (the release register) takes the domain out of reset at the same edge and drops its output.
- R3: The bit layout is the same in both request registers and in status bits [13:0]. Core n uses bit n. SIMD n uses bit n+4. Core-n debug uses bit n+9. L2 uses bit 8 and cluster debug uses bit 13. Zero bits in a write leave their domains unchanged.
- R4: Status register 0x1520 + 8*c shows in bits [13:0] a 1 for each domain in reset. A change appears exactly SETTLE_CYCLES (default 4) clock edges after the reset output changes. The bit then stays at that value while the domain stays in that state.
- R5: Status bits 16+n, 20+n and 24+n report core n's WFI, WFE and debug-acknowledge inputs. Each is visible two clock edges after the input changes.
- R6: When WFI_GATE = 1, an assert request on a core bit (bits 0-3) takes effect only while that core's synchronised WFI is high. If WFI is high at the write, the core reset applies at once. Otherwise the request waits and applies at the edge where synchronised WFI is first seen high. SIMD, debug and cluster bits are never gated.
- R7: A release of a core while a gated assert request for that core is waiting cancels that request. The core stays out of reset when WFI later rises.
- R8: Reading either request register of cluster c returns the current, unsettled reset-state vector of that cluster in bits [13:0]. All other bits read zero.
- R9: Reads at an undefined offset return zero, and writes there change no reset output.
- R10: A write to one cluster's registers changes no domain of any other cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| bus_valid | input | 1 | Register access strobe; each cycle it is high is one access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access; zero otherwise |
| core_wfi | input | NCLU*NPC | Per-core WFI indication, index c*NPC+n, asynchronous |
| core_wfe | input | NCLU*NPC | Per-core WFE indication, asynchronous |
| core_dbgack | input | NCLU*NPC | Per-core debug acknowledge, asynchronous |
| core_rst | output | NCLU*NPC | Core reset, 1 = held in reset |
| simd_rst | output | NCLU*NPC | SIMD unit reset, 1 = held in reset |
| core_dbg_rst | output | NCLU*NPC | Core debug reset, 1 = held in reset |
| l2_rst | output | NCLU | Cluster L2 reset, 1 = held in reset |
| clu_dbg_rst | output | NCLU | Cluster debug reset, 1 = held in reset |

## Verification
A wrong bit in the held reset state shows on a reset output, and on the request-register readback, one edge after the write that caused it. The status copy carries the same error SETTLE_CYCLES edges later. A stale or lost pending gated request can stay hidden until the matching WFI rises. It then shows as a core reset that arrives when it should not, or fails to arrive, three edges after the WFI input changes. Each domain of every cluster is toggled alone, and all outputs are compared against an arithmetic model after each write. This exposes any cross-talk between domains or clusters at once.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int DOM_W      = 14;
  localparam int MAX_CORES  = 4;
  localparam int SIMD_OFS   = 4;
  localparam int L2_BIT     = 8;
  localparam int CDBG_OFS   = 9;
  localparam int CLDBG_BIT  = 13;
  localparam int WFI_OFS    = 16;
  localparam int WFE_OFS    = 20;
  localparam int ACK_OFS    = 24;
  localparam int ADDR_W     = 13;
  localparam int CLU_STRIDE = 8;
  localparam logic [ADDR_W-1:0] ASRT_BASE = 13'h0520;
  localparam logic [ADDR_W-1:0] REL_BASE  = 13'h0524;
  localparam logic [ADDR_W-1:0] STAT_BASE = 13'h1520;

  typedef logic [DOM_W-1:0] dom_vec_t;

  // Domains that exist for a cluster with ncores cores.
  function automatic dom_vec_t dom_mask(input int ncores);
    dom_vec_t m;
    m = '0;
    for (int n = 0; n < MAX_CORES; n++) begin
      if (n < ncores) begin
        m[n]            = 1'b1;
        m[SIMD_OFS + n] = 1'b1;
        m[CDBG_OFS + n] = 1'b1;
      end
    end
    m[L2_BIT]    = 1'b1;
    m[CLDBG_BIT] = 1'b1;
    return m;
  endfunction

  // Domains left running after reset in the boot cluster.
  function automatic dom_vec_t boot_domains();
    dom_vec_t m;
    m = '0;
    m[0]         = 1'b1;
    m[SIMD_OFS]  = 1'b1;
    m[CDBG_OFS]  = 1'b1;
    m[L2_BIT]    = 1'b1;
    m[CLDBG_BIT] = 1'b1;
    return m;
  endfunction

  function automatic dom_vec_t core_bits(input int ncores);
    dom_vec_t m;
    m = '0;
    for (int n = 0; n < MAX_CORES; n++) begin
      if (n < ncores) m[n] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cpu_rst_sync.sv
module cpu_rst_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/cpu_rst_cluster.sv
module cpu_rst_cluster
  import cpu_rst_pkg::*;
#(
  parameter int NPC      = 4,
  parameter int SETTLE   = 4,
  parameter bit WFI_GATE = 1'b1,
  parameter bit IS_BOOT  = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           asrt_we,
  input  logic           rel_we,
  input  dom_vec_t       wdata,
  input  logic [NPC-1:0] wfi_s,
  input  logic [NPC-1:0] wfe_s,
  input  logic [NPC-1:0] ack_s,
  output dom_vec_t       state_o,
  output logic [31:0]    status_o
);
  localparam dom_vec_t MASK      = dom_mask(NPC);
  localparam dom_vec_t CORE_MASK = core_bits(NPC);
  localparam dom_vec_t RST_VAL   = IS_BOOT ? (MASK & ~boot_domains()) : MASK;

  dom_vec_t       state_q, state_d, wmask;
  logic [NPC-1:0] core_set;
  logic [NPC-1:0] pend_q;

  assign wmask = wdata & MASK;

  // Core-reset assertion path: gated by WFI or direct.
  generate
    if (WFI_GATE) begin : g_gate
      logic [NPC-1:0] pend_d;
      always_comb begin
        for (int n = 0; n < NPC; n++) begin
          core_set[n] = (asrt_we && wmask[n] && wfi_s[n]) ||
                        (pend_q[n] && wfi_s[n] && !(rel_we && wmask[n]));
          if (rel_we && wmask[n])       pend_d[n] = 1'b0;
          else if (core_set[n])         pend_d[n] = 1'b0;
          else if (asrt_we && wmask[n] && !state_q[n]) pend_d[n] = 1'b1;
          else                          pend_d[n] = pend_q[n];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
      end

      for (genvar n = 0; n < NPC; n++) begin : g_chk
        p_pend_core_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
          pend_q[n] |-> !state_q[n]);
        p_gate_waits_wfi_r6: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(state_q[n]) |-> $past(wfi_s[n]));
        p_release_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (rel_we && wmask[n]) |=> (!pend_q[n] && !state_q[n]));
      end
    end else begin : g_direct
      always_comb begin
        for (int n = 0; n < NPC; n++) core_set[n] = asrt_we && wmask[n];
      end
      assign pend_q = '0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (asrt_we) state_d = state_d | (wmask & ~CORE_MASK);
    for (int n = 0; n < NPC; n++) begin
      if (core_set[n]) state_d[n] = 1'b1;
    end
    if (rel_we) state_d = state_d & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_VAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // Settling delay line for the status copy of the reset state.
  dom_vec_t stage_q [SETTLE];
  generate
    for (genvar s = 0; s < SETTLE; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= state_q;
        else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    status_o = '0;
    status_o[DOM_W-1:0] = stage_q[SETTLE-1];
    for (int n = 0; n < NPC; n++) begin
      status_o[WFI_OFS + n] = wfi_s[n];
      status_o[WFE_OFS + n] = wfe_s[n];
      status_o[ACK_OFS + n] = ack_s[n];
    end
  end

  p_release_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_we |=> ((state_q & $past(wmask)) == '0));
  p_assert_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    asrt_we |=> ((state_q & $past(wmask & ~CORE_MASK)) == $past(wmask & ~CORE_MASK)));
  p_zero_bits_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_we && (pend_q == '0)) |=> (((state_q ^ $past(state_q)) & ~$past(wmask)) == '0));
endmodule

// File: rtl/cpu_rst_ctrl.sv
module cpu_rst_ctrl
  import cpu_rst_pkg::*;
#(
  parameter int NCLU     = 4,
  parameter int NPC      = 4,
  parameter int SETTLE   = 4,
  parameter bit WFI_GATE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [12:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCLU*NPC-1:0]  core_wfi,
  input  logic [NCLU*NPC-1:0]  core_wfe,
  input  logic [NCLU*NPC-1:0]  core_dbgack,
  output logic [NCLU*NPC-1:0]  core_rst,
  output logic [NCLU*NPC-1:0]  simd_rst,
  output logic [NCLU*NPC-1:0]  core_dbg_rst,
  output logic [NCLU-1:0]      l2_rst,
  output logic [NCLU-1:0]      clu_dbg_rst
);
  localparam int NT = NCLU * NPC;

  logic [NT-1:0]   wfi_s, wfe_s, ack_s;
  logic [NCLU-1:0] hit_a, hit_r, hit_s;
  dom_vec_t        st   [NCLU];
  logic [31:0]     stat [NCLU];
  logic [31:0]     rd;

  cpu_rst_sync #(.W(NT)) u_sync_wfi (.clk(clk), .rst_n(rst_n), .d_async(core_wfi),    .q_sync(wfi_s));
  cpu_rst_sync #(.W(NT)) u_sync_wfe (.clk(clk), .rst_n(rst_n), .d_async(core_wfe),    .q_sync(wfe_s));
  cpu_rst_sync #(.W(NT)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d_async(core_dbgack), .q_sync(ack_s));

  generate
    for (genvar c = 0; c < NCLU; c++) begin : g_clu
      localparam logic [ADDR_W-1:0] A_OFS = ASRT_BASE + ADDR_W'(c * CLU_STRIDE);
      localparam logic [ADDR_W-1:0] R_OFS = REL_BASE  + ADDR_W'(c * CLU_STRIDE);
      localparam logic [ADDR_W-1:0] S_OFS = STAT_BASE + ADDR_W'(c * CLU_STRIDE);

      assign hit_a[c] = bus_valid && (bus_addr == A_OFS);
      assign hit_r[c] = bus_valid && (bus_addr == R_OFS);
      assign hit_s[c] = bus_valid && (bus_addr == S_OFS);

      cpu_rst_cluster #(
        .NPC(NPC), .SETTLE(SETTLE), .WFI_GATE(WFI_GATE), .IS_BOOT(c == 0)
      ) u_clu (
        .clk      (clk),
        .rst_n    (rst_n),
        .asrt_we  (hit_a[c] && bus_write),
        .rel_we   (hit_r[c] && bus_write),
        .wdata    (bus_wdata[DOM_W-1:0]),
        .wfi_s    (wfi_s[c*NPC +: NPC]),
        .wfe_s    (wfe_s[c*NPC +: NPC]),
        .ack_s    (ack_s[c*NPC +: NPC]),
        .state_o  (st[c]),
        .status_o (stat[c])
      );

      for (genvar n = 0; n < NPC; n++) begin : g_core
        assign core_rst[c*NPC+n]     = st[c][n];
        assign simd_rst[c*NPC+n]     = st[c][SIMD_OFS+n];
        assign core_dbg_rst[c*NPC+n] = st[c][CDBG_OFS+n];
      end
      assign l2_rst[c]      = st[c][L2_BIT];
      assign clu_dbg_rst[c] = st[c][CLDBG_BIT];
    end
  endgenerate

  always_comb begin
    rd = '0;
    for (int c = 0; c < NCLU; c++) begin
      if (hit_a[c] || hit_r[c]) rd = 32'(st[c]);
      if (hit_s[c])             rd = stat[c];
    end
  end

  assign bus_rdata = (bus_valid && !bus_write) ? rd : '0;

  p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && ((hit_a | hit_r | hit_s) == '0)) |-> (bus_rdata == '0));
endmodule

// File: tb/cpu_rst_ctrl_test.sv
`timescale 1ns/100ps
module cpu_rst_ctrl_test;
  localparam int NCLU = 4;
  localparam int NPC  = 4;
  localparam int NT   = NCLU*NPC;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NT-1:0] core_wfi = '0, core_wfe = '0, core_dbgack = '0;
  logic [NT-1:0] core_rst, simd_rst, core_dbg_rst;
  logic [NCLU-1:0] l2_rst, clu_dbg_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [13:0] exp_st [NCLU];

  always #2.5 clk = ~clk;

  cpu_rst_ctrl #(.NCLU(NCLU), .NPC(NPC), .SETTLE(SETTLE), .WFI_GATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_wfi(core_wfi), .core_wfe(core_wfe), .core_dbgack(core_dbgack),
    .core_rst(core_rst), .simd_rst(simd_rst), .core_dbg_rst(core_dbg_rst),
    .l2_rst(l2_rst), .clu_dbg_rst(clu_dbg_rst));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] a_ofs(input int c);  return 13'h0520 + 13'(c*8); endfunction
  function automatic logic [12:0] r_ofs(input int c);  return 13'h0524 + 13'(c*8); endfunction
  function automatic logic [12:0] s_ofs(input int c);  return 13'h1520 + 13'(c*8); endfunction

  task automatic chk_outputs(input string req);
    logic [NT-1:0] ec, es, ed;
    logic [NCLU-1:0] el, ek;
    for (int c = 0; c < NCLU; c++) begin
      for (int n = 0; n < NPC; n++) begin
        ec[c*NPC+n] = exp_st[c][n];
        es[c*NPC+n] = exp_st[c][4+n];
        ed[c*NPC+n] = exp_st[c][9+n];
      end
      el[c] = exp_st[c][8];
      ek[c] = exp_st[c][13];
    end
    chk(req, 32'(core_rst), 32'(ec));
    chk(req, 32'(simd_rst), 32'(es));
    chk(req, 32'(core_dbg_rst), 32'(ed));
    chk(req, 32'({l2_rst, clu_dbg_rst}), 32'({el, ek}));
  endtask

  task automatic do_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [12:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    logic [13:0] prev;
    for (int c = 0; c < NCLU; c++) exp_st[c] = 14'h3FFF;
    exp_st[0] = 14'h1CEE;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(1);

    // R1: reset state on outputs and settled status
    chk_outputs("R1");
    for (int c = 0; c < NCLU; c++) begin
      do_read(s_ofs(c), rv);
      chk("R1 status", rv, 32'(exp_st[c]));
    end

    core_wfi = '1;
    tick(3);

    // R2 R3 R4 R8 R10: toggle each domain alone in each cluster
    for (int c = 0; c < NCLU; c++) begin
      for (int b = 0; b < 14; b++) begin
        for (int ph = 0; ph < 2; ph++) begin
          do_read(s_ofs(c), rv);
          prev = rv[13:0];
          if (ph == 0) begin
            do_write(a_ofs(c), 32'(1) << b);
            exp_st[c][b] = 1'b1;
          end else begin
            do_write(r_ofs(c), 32'(1) << b);
            exp_st[c][b] = 1'b0;
          end
          chk_outputs(ph == 0 ? "R2 assert R3 R10" : "R2 release R3 R10");
          do_read(a_ofs(c), rv);
          chk("R8 assert-reg readback", rv, 32'(exp_st[c]));
          do_read(r_ofs(c), rv);
          chk("R8 release-reg readback", rv, 32'(exp_st[c]));
          if (prev != exp_st[c]) begin
            tick(SETTLE-1);
            do_read(s_ofs(c), rv);
            chk("R4 status still old", 32'(rv[13:0]), 32'(prev));
            tick(1);
            do_read(s_ofs(c), rv);
            chk("R4 status settled", 32'(rv[13:0]), 32'(exp_st[c]));
          end
        end
      end
    end

    // R3 multi-bit patterns: zero bits untouched
    do_write(a_ofs(3), 32'h0000_2A55);
    exp_st[3] = exp_st[3] | 14'h2A55;
    chk_outputs("R3 pattern assert");
    do_write(r_ofs(3), 32'hFFFF_0041);
    exp_st[3] = exp_st[3] & ~14'h0041;
    chk_outputs("R3 pattern release");
    tick(SETTLE);
    do_read(s_ofs(3), rv);
    chk("R4 held in reset", 32'(rv[13:0]), 32'(exp_st[3]));
    tick(10);
    do_read(s_ofs(3), rv);
    chk("R4 still held", 32'(rv[13:0]), 32'(exp_st[3]));

    // R5: synchronised status inputs
    for (int i = 0; i < NT; i++) begin
      core_wfe[i]    = ((i / NPC) + (i % NPC)) % 2 == 1;
      core_dbgack[i] = (i % 3) == 0;
    end
    core_wfi[5] = 1'b0;
    tick(1);
    do_read(s_ofs(1), rv);
    chk("R5 not yet visible", rv[31:16], 16'h000F);
    tick(1);
    for (int c = 0; c < NCLU; c++) begin
      logic [31:0] e;
      e = 32'(exp_st[c]);
      for (int n = 0; n < NPC; n++) begin
        e[16+n] = core_wfi[c*NPC+n];
        e[20+n] = core_wfe[c*NPC+n];
        e[24+n] = core_dbgack[c*NPC+n];
      end
      do_read(s_ofs(c), rv);
      chk("R5 status inputs", rv, e);
    end
    core_wfi[5] = 1'b1;

    // R6: gated core reset waits for WFI (cluster 1, core 2)
    core_wfi[1*NPC+2] = 1'b0;
    tick(3);
    do_write(a_ofs(1), 32'h0000_0044);
    exp_st[1][6] = 1'b1;
    chk_outputs("R6 core waits, simd immediate");
    tick(4);
    chk_outputs("R6 still waiting");
    core_wfi[1*NPC+2] = 1'b1;
    tick(2);
    chk_outputs("R6 before synced WFI");
    tick(1);
    exp_st[1][2] = 1'b1;
    chk_outputs("R6 applied on WFI");

    // R7: release cancels a waiting gated request (cluster 2, core 3)
    do_write(r_ofs(2), 32'h0000_0008);
    exp_st[2][3] = 1'b0;
    core_wfi[2*NPC+3] = 1'b0;
    tick(3);
    do_write(a_ofs(2), 32'h0000_0008);
    chk_outputs("R7 waiting");
    do_write(r_ofs(2), 32'h0000_0008);
    core_wfi[2*NPC+3] = 1'b1;
    tick(6);
    chk_outputs("R7 cancelled");
    do_read(a_ofs(2), rv);
    chk("R7 readback", rv, 32'(exp_st[2]));

    // R9: undefined offsets
    do_write(13'h0540, 32'hFFFF_FFFF);
    do_write(13'h1524, 32'hFFFF_FFFF);
    do_write(13'h0000, 32'hFFFF_FFFF);
    do_write(13'h051C, 32'hFFFF_FFFF);
    chk_outputs("R9 writes ignored");
    do_read(13'h0540, rv);
    chk("R9 read zero", rv, 32'h0);
    do_read(13'h1524, rv);
    chk("R9 read zero", rv, 32'h0);
    do_read(13'h0000, rv);
    chk("R9 read zero", rv, 32'h0);

    finish_run();
  end
endmodule